// File: doc/BRIEF.md
# Cache Maintenance Region Sequencer

The sequencer turns a single maintenance request into a series of per-line commands for a downstream cache maintenance engine. A request names an operation, a start address, a byte length and a flag that selects between a region request and a whole-cache request. A region request produces one address-matched ("hit") command for every cache line that the byte range touches. The line count includes the misalignment of the start address, so an unaligned range can need one more line than its length alone would suggest. A whole-cache request walks the index space with indexed commands. It moves in steps of four line offsets, and the number of steps depends on whether the operation has to visit every way.

Commands leave through a valid/ready handshake. Address and operation hold steady while the engine stalls. A one-cycle done pulse follows the last accepted command. A request whose line count works out to zero produces no commands and signals done straight away. Executing the commands is the engine's job and is outside this block.

Top module: `cmaint_seq`

## Requirements
- R1: After reset `cmdValid` and `done` are low and `reqReady` is high.
- R2: A region request (`reqWhole`=0) emits exactly (length + (start mod line size) + line size − 1) / line size commands, using integer division.
- R3: A request whose command count is zero emits no command. `done` is high in the cycle after the request is accepted.
- R4: Region command i (counting from 0) carries address start + i × line size and `cmdIndexed`=0. `cmdOp` repeats the request code: 0 invalidate, 1 writeback, 2 writeback-invalidate, 3 lock, 4 unlock.
- R5: A whole-cache request (`reqWhole`=1) emits indexed commands (`cmdIndexed`=1) at addresses 0, L, 2L, … in steps of four offsets. For invalidate it runs cache size / (L × ways × 4) steps, which gives 32 commands with the default parameters.
- R6: A whole-cache writeback, writeback-invalidate or unlock uses a way factor of 1, which gives 64 commands with the default parameters. A whole-cache lock emits no commands.
- R7: A request is accepted only while `reqReady` is high, and `reqReady` is high only while idle. A request held during a run has no effect on the commands in progress and is not taken up afterwards once it is withdrawn.
- R8: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdAddr` and `cmdOp` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle right after the handshake of the final command.
- R10: A configuration is refused at elaboration if the cache size is not a multiple of line size × ways × 4, if the line size lies outside 16 to 64 bytes, if the way count lies outside 1 to 4, or if the cache is smaller than 1024 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqOp | input | 3 | Operation code (see R4) |
| reqWhole | input | 1 | 1 = whole-cache sweep, 0 = address region |
| reqAddr | input | ADDR_W | Region start byte address |
| reqLen | input | LEN_W | Region length in bytes |
| cmdValid | output | 1 | Command present |
| cmdReady | input | 1 | Engine takes the command |
| cmdAddr | output | ADDR_W | Line address (region) or index offset (sweep) |
| cmdOp | output | 3 | Operation code of the command |
| cmdIndexed | output | 1 | 1 = indexed command, 0 = hit command |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
A new request can arrive in the same cycle as the handshake of a run's final command, because a requester may hold `reqValid` high across the whole run. The bench provokes this by keeping a conflicting request (a different operation, address and mode) asserted from the moment the first request is accepted until `done` appears. It then checks three things. Every command still matches the original request. `reqReady` stays low through the final handshake and the done cycle. After the request is withdrawn the block returns to idle without emitting anything further. A second overlap, a stall on the last command just before `done`, is judged by the pulse landing exactly one cycle after the delayed handshake.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

  typedef enum logic [2:0] {
    OP_INV    = 3'd0,
    OP_WB     = 3'd1,
    OP_WBINV  = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4
  } maintOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture request, compute command count
    logic step;   // one command handshake completed
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_e;

endpackage

// File: rtl/cmseq_dp.sv
module cmseq_dp
  import cmseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 2,
  parameter int CNT_W       = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        reqOp,
  input  logic              reqWhole,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqZero,
  output logic              lastCmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [2:0]        cmdOp,
  output logic              cmdIndexed
);

  localparam int LINE_LOG2   = $clog2(LINE_BYTES);
  localparam int SUM_W       = LEN_W + 2;
  localparam int STEPS_ALLW  = CACHE_BYTES / (LINE_BYTES * WAYS * 4);
  localparam int STEPS_ONEW  = CACHE_BYTES / (LINE_BYTES * 4);
  localparam logic [ADDR_W-1:0] GROUP_BYTES = ADDR_W'(LINE_BYTES * 4);

  // region line count: length plus start skew, rounded up to whole lines
  logic [LINE_LOG2-1:0] startSkew;
  logic [SUM_W-1:0]     spanBytes;
  logic [CNT_W-1:0]     regionCnt;
  logic [CNT_W-1:0]     sweepSteps;
  logic [CNT_W-1:0]     reqCnt;

  always_comb begin
    startSkew = reqAddr[LINE_LOG2-1:0];
    spanBytes = {2'b00, reqLen} + SUM_W'(startSkew) + SUM_W'(LINE_BYTES - 1);
    regionCnt = CNT_W'(spanBytes >> LINE_LOG2);
    unique case (reqOp)
      OP_INV:                     sweepSteps = CNT_W'(STEPS_ALLW);
      OP_WB, OP_WBINV, OP_UNLOCK: sweepSteps = CNT_W'(STEPS_ONEW);
      default:                    sweepSteps = '0;
    endcase
    reqCnt  = reqWhole ? (sweepSteps << 2) : regionCnt;
    reqZero = (reqCnt == '0);
  end

  // running state
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        subIdx;
  logic [CNT_W-1:0]  remaining;
  logic [2:0]        opReg;
  logic              wholeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      subIdx    <= '0;
      remaining <= '0;
      opReg     <= '0;
      wholeReg  <= 1'b0;
    end else if (strobe.load) begin
      baseAddr  <= reqWhole ? '0 : reqAddr;
      subIdx    <= '0;
      remaining <= reqCnt;
      opReg     <= reqOp;
      wholeReg  <= reqWhole;
    end else if (strobe.step) begin
      remaining <= remaining - 1'b1;
      if (subIdx == 2'd3) begin
        subIdx   <= '0;
        baseAddr <= baseAddr + GROUP_BYTES;
      end else begin
        subIdx <= subIdx + 2'd1;
      end
    end
  end

  always_comb begin
    cmdAddr    = baseAddr + (ADDR_W'(subIdx) << LINE_LOG2);
    cmdOp      = opReg;
    cmdIndexed = wholeReg;
    lastCmd    = (remaining == CNT_W'(1));
  end

endmodule

// File: rtl/cmseq_ctrl.sv
module cmseq_ctrl
  import cmseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cmdReady,
  input  logic       reqZero,
  input  logic       lastCmd,
  output logic       reqReady,
  output logic       cmdValid,
  output logic       done,
  output seqStrobe_t strobe
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    reqReady    = (state == ST_IDLE);
    cmdValid    = (state == ST_RUN);
    done        = (state == ST_FIN);
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stateNext   = reqZero ? ST_FIN : ST_RUN;
      end
      ST_RUN: if (cmdReady) begin
        strobe.step = 1'b1;
        if (lastCmd) stateNext = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cmseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic              reqWhole,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [2:0]        cmdOp,
  output logic              cmdIndexed,
  output logic              done
);

  localparam int CNT_W = LEN_W + 2;

  // R10: unsupported geometry is refused at elaboration
  if ((CACHE_BYTES % (LINE_BYTES * WAYS * 4)) != 0 || CACHE_BYTES < 1024 ||
      LINE_BYTES < 16 || LINE_BYTES > 64 || WAYS < 1 || WAYS > 4 ||
      (1 << $clog2(LINE_BYTES)) != LINE_BYTES ||
      (CACHE_BYTES / LINE_BYTES) >= (1 << CNT_W)) begin : g_badCfg
    $error("cmaint_seq: cache geometry outside supported range");
  end

  seqStrobe_t strobe;
  logic       reqZero;
  logic       lastCmd;

  cmseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .reqZero  (reqZero),
    .lastCmd  (lastCmd),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .done     (done),
    .strobe   (strobe)
  );

  cmseq_dp #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_BYTES  (LINE_BYTES),
    .WAYS        (WAYS),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOp      (reqOp),
    .reqWhole   (reqWhole),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqZero    (reqZero),
    .lastCmd    (lastCmd),
    .cmdAddr    (cmdAddr),
    .cmdOp      (cmdOp),
    .cmdIndexed (cmdIndexed)
  );

endmodule

// File: rtl/cmseq_chk.sv
module cmseq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [2:0]        cmdOp,
  input logic              cmdIndexed,
  input logic              done
);

  localparam int LINE_LOG2 = $clog2(LINE_BYTES);

  // R8: a stalled command holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdOp)));

  // R4 / R5: consecutive commands of one run are one line apart
  a_r4_line_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=>
      (!cmdValid || cmdAddr == $past(cmdAddr) + ADDR_W'(LINE_BYTES)));

  // R5: indexed sweep addresses are line aligned
  a_r5_sweep_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIndexed) |-> (cmdAddr[LINE_LOG2-1:0] == '0));

  // R7: never ready for a request while a command is offered
  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && (cmdValid || done)));

  // R9: done is a single-cycle pulse, never alongside a command
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cmdValid ##1 !done));

  // R9: done follows directly on the final handshake or an empty request
  a_r9_done_after: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(cmdValid && cmdReady) || $past(reqReady)));

endmodule

bind cmaint_seq cmseq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdAddr    (cmdAddr),
  .cmdOp      (cmdOp),
  .cmdIndexed (cmdIndexed),
  .done       (done)
);

// File: tb/test_cmaint_seq.sv
`timescale 1ns/1ps
module test_cmaint_seq;

  localparam int LINE = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = '0;
  logic        reqWhole = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [11:0] reqLen = '0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdAddr;
  logic [2:0]  cmdOp;
  logic        cmdIndexed;
  logic        done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  cmaint_seq i_cmaint_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqWhole(reqWhole), .reqAddr(reqAddr), .reqLen(reqLen),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .cmdOp(cmdOp), .cmdIndexed(cmdIndexed), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic        whole;
    logic [31:0] st;
    logic [11:0] ln;
    logic [7:0]  cnt;
  } vec_t;

  // op codes: 0 inv, 1 wb, 2 wbinv, 3 lock, 4 unlock
  localparam vec_t VECS [11] = '{
    '{3'd0, 1'b0, 32'h100, 12'd32, 8'd2},   // R2 aligned
    '{3'd1, 1'b0, 32'h104, 12'd32, 8'd3},   // R2 skew adds a line
    '{3'd3, 1'b0, 32'h20F, 12'd1,  8'd1},   // R2 single byte at line end
    '{3'd4, 1'b0, 32'h300, 12'd0,  8'd0},   // R3 empty region
    '{3'd2, 1'b0, 32'h3F8, 12'd9,  8'd2},   // R2 straddles a line boundary
    '{3'd0, 1'b1, 32'h0,   12'd0,  8'd32},  // R5 invalidate all ways
    '{3'd1, 1'b1, 32'h0,   12'd0,  8'd64},  // R6 writeback
    '{3'd2, 1'b1, 32'h0,   12'd0,  8'd64},  // R6 writeback-invalidate
    '{3'd4, 1'b1, 32'h0,   12'd0,  8'd64},  // R6 unlock
    '{3'd3, 1'b1, 32'h0,   12'd0,  8'd0},   // R6 whole lock emits nothing
    '{3'd0, 1'b0, 32'h7,   12'd0,  8'd1}    // R2 zero length, skewed start
  };

  // Called at a negedge in idle; returns at a negedge after done.
  task automatic run_req(input vec_t v, input bit holdBusy, input string tag);
    int seen = 0;
    int cyc = 0;
    bit gotDone = 0;
    bit expectDone;
    bit pStall = 0;
    logic [31:0] pAddr = '0;
    logic [2:0]  pOp = '0;
    logic [31:0] expAddr;
    expectDone = (v.cnt == 0);
    reqValid = 1'b1; reqOp = v.op; reqWhole = v.whole; reqAddr = v.st; reqLen = v.ln;
    check(reqReady == 1'b1, {"R7 ready before accept ", tag}, reqReady, 1);
    @(negedge clk);
    if (holdBusy) begin
      reqOp = 3'd3; reqWhole = 1'b0; reqAddr = 32'hABC; reqLen = 12'd40;
    end else begin
      reqValid = 1'b0;
    end
    while (!gotDone && cyc < 2000) begin
      if (pStall) begin
        check(cmdValid && cmdAddr == pAddr && cmdOp == pOp, {"R8 stall hold ", tag}, cmdAddr, pAddr);
      end
      check(done == expectDone, {"R9 done timing ", tag}, done, expectDone);
      if (done) begin
        gotDone = 1;
        check(cmdValid == 1'b0, {"R9 no command with done ", tag}, cmdValid, 0);
        check(reqReady == 1'b0, {"R7 busy during done ", tag}, reqReady, 0);
        reqValid = 1'b0;
        cmdReady = 1'b0;
      end else if (cmdValid) begin
        check(reqReady == 1'b0, {"R7 busy while running ", tag}, reqReady, 0);
        expAddr = v.whole ? 32'(seen * LINE) : v.st + 32'(seen * LINE);
        check(cmdAddr == expAddr, {v.whole ? "R5 sweep addr " : "R4 region addr ", tag}, cmdAddr, expAddr);
        check(cmdOp == v.op, {"R4 op echo ", tag}, cmdOp, v.op);
        check(cmdIndexed == v.whole, {"R4 R5 kind ", tag}, cmdIndexed, v.whole);
        cmdReady = ((cyc % 3) != 1) && !(seen == int'(v.cnt) - 1 && cyc % 2 == 0 && !pStall);
        pStall = !cmdReady;
        pAddr = cmdAddr; pOp = cmdOp;
        if (cmdReady) begin
          seen++;
          if (seen == int'(v.cnt)) expectDone = 1;
        end
      end else begin
        cmdReady = 1'b0;
        pStall = 0;
      end
      cyc++;
      @(negedge clk);
    end
    cmdReady = 1'b0;
    check(gotDone, {"R9 done seen ", tag}, gotDone, 1);
    check(seen == int'(v.cnt), {v.whole ? "R5 R6 count " : "R2 R3 count ", tag}, seen, v.cnt);
    check(reqReady == 1'b1 && cmdValid == 1'b0 && done == 1'b0,
          {"R7 idle after run ", tag}, {reqReady, cmdValid, done}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(cmdValid == 1'b0, "R1 cmdValid after reset", cmdValid, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      run_req(VECS[i], 1'b0, $sformatf("vec%0d", i));
    end

    // R7: conflicting request held across the run and the final handshake
    run_req(VECS[6], 1'b1, "busy-hold whole wb");
    run_req(VECS[1], 1'b1, "busy-hold region");

    // R3: back-to-back empty requests each pulse done once
    run_req(VECS[3], 1'b0, "empty again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule